// File: doc/BRIEF.md
# Exception Entry Sequencer

This block performs the hardware side of entering a software-exception handler on a 32-bit little-endian processor. When a trap request arrives together with the live program counter, status word and stack pointer, the block pushes a two-slot return frame to memory. The PC is stored as a word directly below the stack pointer, and the status word as a halfword below that. It then commits a new stack pointer, a status word with interrupts disabled and a fixed handler address, which the fetch unit takes as its next PC.

Memory writes leave through a simple write port with a valid/ready handshake. The port issues one transfer per handshake and places each byte on the lane that matches its address. When the evaluation-board option is sampled high with the request, a third transfer follows the frame. It is a single byte that sets the system-error flag in a register of the interrupt controller.

Both trap causes, an access to an unmapped address and a misaligned access, run the same sequence. The cause that was accepted is reported next to the committed state. A guard detects a second request that arrives while an entry is in flight. It flags the nesting and performs the nested entry without stacking anything.

Top module: `exc_entry_seq`

## Requirements
- R1: While reset is asserted and after its release, `wr_valid`, `entry_done`, `entry_busy` and `nest_err` are 0, and `new_pc`, `new_psw` and `new_sp` are 0.
- R2: The first write of an entry is a word (`wr_size` = 2) at address `cur_sp` - 4 carrying `cur_pc`, with `wr_be` = 4'b1111 for a word-aligned stack pointer.
- R3: The second write is a halfword (`wr_size` = 1) at `cur_sp` - 8 carrying `cur_psw` in `wr_data[15:0]`, with `wr_be` = 4'b0011 for a word-aligned stack pointer.
- R4: If `flag_wr_en` was 1 at acceptance, a third write follows: a byte (`wr_size` = 0) at 0x34000103 with value 0x04 in `wr_data[31:24]` and `wr_be` = 4'b1000. If `flag_wr_en` was 0, no third write is issued.
- R5: A pending write keeps `wr_valid`, `wr_addr`, `wr_data`, `wr_be` and `wr_size` unchanged until `wr_ready` is 1. Each handshake retires exactly one write, and writes retire in the order PC, PSW, flag.
- R6: `entry_done` is high for one cycle per entry, in the cycle after the last handshake. In that cycle `new_pc` = 0x40000008, `new_psw` = `cur_psw` with bit 11 (interrupt enable) cleared, and `new_sp` = `cur_sp` - 8 modulo 2^32. The committed values hold until the next commit.
- R7: Byte lanes that a write does not use have their `wr_be` bit clear and carry zero data. Multi-byte values are little-endian, with bits [7:0] on the lane given by the low address bits.
- R8: A trap request that arrives while `entry_busy` is 1 raises `nest_err` in the next cycle and adds no memory writes. Right after the first `entry_done`, a second `entry_done` cycle follows. In it `new_sp` is a further 8 lower, `new_pc` is 0x40000008 and interrupts stay disabled.
- R9: `entry_busy` is 1 from the cycle after acceptance up to the last handshake, and is 0 in the `entry_done` cycle.
- R10: `trap_cause` (0 = unmapped access, 1 = misaligned access) does not change the write sequence. `entry_cause` shows the accepted cause from the `entry_done` cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trap_req | input | 1 | Trap request, sampled each cycle |
| trap_cause | input | 1 | 0 unmapped access, 1 misaligned access |
| cur_pc | input | 32 | PC to be saved |
| cur_psw | input | 16 | Status word to be saved |
| cur_sp | input | 32 | Stack pointer at trap time |
| flag_wr_en | input | 1 | Request the system-error flag byte write |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Memory accepts the write |
| wr_addr | output | 32 | Byte address of the write |
| wr_data | output | 32 | Lane-steered write data |
| wr_be | output | 4 | Byte-lane enables |
| wr_size | output | 2 | 0 byte, 1 halfword, 2 word |
| new_pc | output | 32 | Committed fetch address |
| new_psw | output | 16 | Committed status word |
| new_sp | output | 32 | Committed stack pointer |
| entry_cause | output | 1 | Cause of the last committed entry |
| entry_done | output | 1 | Commit strobe |
| entry_busy | output | 1 | Entry in flight |
| nest_err | output | 1 | Nested request detected |

## Verification
The assertions check the following on every cycle: the write port holds steady under backpressure; writes appear only while busy; busy and done never overlap; the flag byte always goes to its fixed address with its fixed value and a single lane; every done cycle shows the handler address with interrupts disabled; and a nest indication always follows a request. The bench scenarios are needed for the rest: the exact frame addresses and data taken from the sampled context, the order and count of writes with and without the flag option, stack-pointer wrap-around, the second commit of a nested entry, and the cause reported for each entry.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_PUSH_PC   = 3'd1,
    ST_PUSH_PSW  = 3'd2,
    ST_PUSH_FLAG = 3'd3,
    ST_DONE      = 3'd4
  } seq_state_t;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } wr_size_t;

endpackage

// File: rtl/exc_seq_fsm.sv
module exc_seq_fsm
  import exc_entry_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       trap_req,
  input  logic       wr_ready,
  input  logic       flag_en,
  output seq_state_t state_q,
  output logic       accept,
  output logic       chain,
  output logic       load_full,
  output logic       done,
  output logic       busy,
  output logic       nest_err
);

  seq_state_t state_d;
  logic       pend_q, pend_d;
  logic       nerr_q, nerr_d;
  logic       nest_hit;

  // status decode
  always_comb begin
    busy      = (state_q == ST_PUSH_PC) || (state_q == ST_PUSH_PSW) ||
                (state_q == ST_PUSH_FLAG);
    done      = (state_q == ST_DONE);
    chain     = done && pend_q;
    accept    = trap_req && ((state_q == ST_IDLE) || (done && !pend_q));
    nest_hit  = trap_req && (busy || chain);
    load_full = wr_ready && (((state_q == ST_PUSH_PSW) && !flag_en) ||
                             (state_q == ST_PUSH_FLAG));
  end

  // next state
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:      if (accept) state_d = ST_PUSH_PC;
      ST_PUSH_PC:   if (wr_ready) state_d = ST_PUSH_PSW;
      ST_PUSH_PSW:  if (wr_ready) state_d = flag_en ? ST_PUSH_FLAG : ST_DONE;
      ST_PUSH_FLAG: if (wr_ready) state_d = ST_DONE;
      ST_DONE: begin
        if (pend_q)      state_d = ST_DONE;
        else if (accept) state_d = ST_PUSH_PC;
        else             state_d = ST_IDLE;
      end
      default:      state_d = ST_IDLE;
    endcase
  end

  // nested request bookkeeping: a chained commit consumes one pending request
  always_comb begin
    pend_d = chain ? nest_hit : (pend_q || nest_hit);
    nerr_d = nest_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pend_q  <= 1'b0;
      nerr_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
      nerr_q  <= nerr_d;
    end
  end

  assign nest_err = nerr_q;

endmodule

// File: rtl/exc_ctx_regs.sv
module exc_ctx_regs #(
  parameter int                 WORD_W = 32,
  parameter int                 PSW_W  = 16,
  parameter int                 IE_POS = 11,
  parameter logic [WORD_W-1:0]  VECTOR = 32'h4000_0008
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              load_full,
  input  logic              chain,
  input  logic [WORD_W-1:0] cur_pc,
  input  logic [PSW_W-1:0]  cur_psw,
  input  logic [WORD_W-1:0] cur_sp,
  input  logic              flag_wr_en,
  input  logic              trap_cause,
  output logic [WORD_W-1:0] pc_l,
  output logic [PSW_W-1:0]  psw_l,
  output logic [WORD_W-1:0] sp_l,
  output logic              flag_l,
  output logic [WORD_W-1:0] new_pc,
  output logic [PSW_W-1:0]  new_psw,
  output logic [WORD_W-1:0] new_sp,
  output logic              entry_cause
);

  localparam int                WORD_B   = WORD_W / 8;
  localparam logic [WORD_W-1:0] FRAME_B  = WORD_W'(2 * WORD_B);
  localparam logic [PSW_W-1:0]  IE_MASK  = PSW_W'(1) << IE_POS;

  logic              cause_l;
  logic [WORD_W-1:0] pc_l_d, sp_l_d, npc_d, nsp_d;
  logic [PSW_W-1:0]  psw_l_d, npsw_d;
  logic              flag_l_d, cause_l_d, ncause_d;
  logic              cap_en, out_en;

  assign cap_en = accept;
  assign out_en = load_full || chain;

  // capture of the trap context
  always_comb begin
    pc_l_d    = cur_pc;
    psw_l_d   = cur_psw;
    sp_l_d    = cur_sp;
    flag_l_d  = flag_wr_en;
    cause_l_d = trap_cause;
  end

  // committed state: a full entry starts from the captured context,
  // a chained entry builds on the state committed one cycle earlier
  always_comb begin
    npc_d = VECTOR;
    if (chain) begin
      npsw_d   = new_psw & ~IE_MASK;
      nsp_d    = new_sp - FRAME_B;
      ncause_d = entry_cause;
    end else begin
      npsw_d   = psw_l & ~IE_MASK;
      nsp_d    = sp_l - FRAME_B;
      ncause_d = cause_l;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_l    <= '0;
      psw_l   <= '0;
      sp_l    <= '0;
      flag_l  <= 1'b0;
      cause_l <= 1'b0;
    end else if (cap_en) begin
      pc_l    <= pc_l_d;
      psw_l   <= psw_l_d;
      sp_l    <= sp_l_d;
      flag_l  <= flag_l_d;
      cause_l <= cause_l_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      new_pc      <= '0;
      new_psw     <= '0;
      new_sp      <= '0;
      entry_cause <= 1'b0;
    end else if (out_en) begin
      new_pc      <= npc_d;
      new_psw     <= npsw_d;
      new_sp      <= nsp_d;
      entry_cause <= ncause_d;
    end
  end

endmodule

// File: rtl/exc_wr_lane.sv
module exc_wr_lane
  import exc_entry_pkg::*;
#(
  parameter int                WORD_W    = 32,
  parameter int                PSW_W     = 16,
  parameter logic [WORD_W-1:0] FLAG_ADDR = 32'h3400_0103,
  parameter logic [7:0]        FLAG_VAL  = 8'h04
) (
  input  seq_state_t          state_q,
  input  logic [WORD_W-1:0]   pc_l,
  input  logic [PSW_W-1:0]    psw_l,
  input  logic [WORD_W-1:0]   sp_l,
  output logic                wr_valid,
  output logic [WORD_W-1:0]   wr_addr,
  output logic [WORD_W-1:0]   wr_data,
  output logic [WORD_W/8-1:0] wr_be,
  output logic [1:0]          wr_size
);

  localparam int                LANES   = WORD_W / 8;
  localparam int                OFF_W   = $clog2(LANES);
  localparam logic [WORD_W-1:0] PC_SLOT  = WORD_W'(LANES);
  localparam logic [WORD_W-1:0] PSW_SLOT = WORD_W'(2 * LANES);
  localparam int                PSW_B   = PSW_W / 8;

  logic [WORD_W-1:0] val;
  logic [OFF_W:0]    nbytes;
  logic [OFF_W-1:0]  off;
  wr_size_t          size_e;

  // select the transfer belonging to the current step
  always_comb begin
    wr_valid = 1'b0;
    wr_addr  = '0;
    val      = '0;
    nbytes   = '0;
    size_e   = SZ_BYTE;
    unique case (state_q)
      ST_PUSH_PC: begin
        wr_valid = 1'b1;
        wr_addr  = sp_l - PC_SLOT;
        val      = pc_l;
        nbytes   = (OFF_W+1)'(LANES);
        size_e   = SZ_WORD;
      end
      ST_PUSH_PSW: begin
        wr_valid = 1'b1;
        wr_addr  = sp_l - PSW_SLOT;
        val      = WORD_W'(psw_l);
        nbytes   = (OFF_W+1)'(PSW_B);
        size_e   = SZ_HALF;
      end
      ST_PUSH_FLAG: begin
        wr_valid = 1'b1;
        wr_addr  = FLAG_ADDR;
        val      = WORD_W'(FLAG_VAL);
        nbytes   = (OFF_W+1)'(1);
        size_e   = SZ_BYTE;
      end
      default: ;
    endcase
    off     = wr_addr[OFF_W-1:0];
    wr_size = size_e;
  end

  // little-endian lane steering, one slice per byte lane
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam logic [OFF_W+1:0] LANE_IDX = (OFF_W+2)'(g);
    logic             hit;
    logic [OFF_W-1:0] rel;
    always_comb begin
      hit = wr_valid &&
            (LANE_IDX >= {2'b00, off}) &&
            (LANE_IDX < ({2'b00, off} + {1'b0, nbytes}));
      rel = OFF_W'(g) - off;
      wr_be[g]         = hit;
      wr_data[g*8 +: 8] = hit ? val[{rel, 3'b000} +: 8] : 8'h00;
    end
  end

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_entry_pkg::*;
#(
  parameter int          WORD_W    = 32,
  parameter int          PSW_W     = 16,
  parameter int          IE_POS    = 11,
  parameter logic [31:0] VECTOR    = 32'h4000_0008,
  parameter logic [31:0] FLAG_ADDR = 32'h3400_0103,
  parameter logic [7:0]  FLAG_VAL  = 8'h04
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                trap_req,
  input  logic                trap_cause,
  input  logic [WORD_W-1:0]   cur_pc,
  input  logic [PSW_W-1:0]    cur_psw,
  input  logic [WORD_W-1:0]   cur_sp,
  input  logic                flag_wr_en,
  output logic                wr_valid,
  input  logic                wr_ready,
  output logic [WORD_W-1:0]   wr_addr,
  output logic [WORD_W-1:0]   wr_data,
  output logic [WORD_W/8-1:0] wr_be,
  output logic [1:0]          wr_size,
  output logic [WORD_W-1:0]   new_pc,
  output logic [PSW_W-1:0]    new_psw,
  output logic [WORD_W-1:0]   new_sp,
  output logic                entry_cause,
  output logic                entry_done,
  output logic                entry_busy,
  output logic                nest_err
);

  seq_state_t        state_q;
  logic              accept, chain, load_full;
  logic [WORD_W-1:0] pc_l, sp_l;
  logic [PSW_W-1:0]  psw_l;
  logic              flag_l;

  exc_seq_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .trap_req  (trap_req),
    .wr_ready  (wr_ready),
    .flag_en   (flag_l),
    .state_q   (state_q),
    .accept    (accept),
    .chain     (chain),
    .load_full (load_full),
    .done      (entry_done),
    .busy      (entry_busy),
    .nest_err  (nest_err)
  );

  exc_ctx_regs #(
    .WORD_W (WORD_W),
    .PSW_W  (PSW_W),
    .IE_POS (IE_POS),
    .VECTOR (WORD_W'(VECTOR))
  ) u_ctx (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept      (accept),
    .load_full   (load_full),
    .chain       (chain),
    .cur_pc      (cur_pc),
    .cur_psw     (cur_psw),
    .cur_sp      (cur_sp),
    .flag_wr_en  (flag_wr_en),
    .trap_cause  (trap_cause),
    .pc_l        (pc_l),
    .psw_l       (psw_l),
    .sp_l        (sp_l),
    .flag_l      (flag_l),
    .new_pc      (new_pc),
    .new_psw     (new_psw),
    .new_sp      (new_sp),
    .entry_cause (entry_cause)
  );

  exc_wr_lane #(
    .WORD_W    (WORD_W),
    .PSW_W     (PSW_W),
    .FLAG_ADDR (WORD_W'(FLAG_ADDR)),
    .FLAG_VAL  (FLAG_VAL)
  ) u_lane (
    .state_q  (state_q),
    .pc_l     (pc_l),
    .psw_l    (psw_l),
    .sp_l     (sp_l),
    .wr_valid (wr_valid),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .wr_be    (wr_be),
    .wr_size  (wr_size)
  );

endmodule

// File: rtl/exc_entry_seq_chk.sv
module exc_entry_seq_chk #(
  parameter int          WORD_W    = 32,
  parameter int          PSW_W     = 16,
  parameter int          IE_POS    = 11,
  parameter logic [31:0] VECTOR    = 32'h4000_0008,
  parameter logic [31:0] FLAG_ADDR = 32'h3400_0103,
  parameter logic [7:0]  FLAG_VAL  = 8'h04
) (
  input logic                clk,
  input logic                rst_n,
  input logic                trap_req,
  input logic                wr_valid,
  input logic                wr_ready,
  input logic [WORD_W-1:0]   wr_addr,
  input logic [WORD_W-1:0]   wr_data,
  input logic [WORD_W/8-1:0] wr_be,
  input logic [1:0]          wr_size,
  input logic [WORD_W-1:0]   new_pc,
  input logic [PSW_W-1:0]    new_psw,
  input logic                entry_done,
  input logic                entry_busy,
  input logic                nest_err
);

  a_r5_hold_under_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data) &&
                                 $stable(wr_be) && $stable(wr_size)));

  a_r9_write_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> entry_busy);

  a_r9_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    entry_done |-> !entry_busy);

  a_r6_done_vector: assert property (@(posedge clk) disable iff (!rst_n)
    entry_done |-> (new_pc == WORD_W'(VECTOR)) && !new_psw[IE_POS]);

  a_r4_flag_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_size == 2'd0) |->
      (wr_addr == WORD_W'(FLAG_ADDR)) && $onehot0(wr_be) && (wr_be != '0) &&
      (wr_data[8*FLAG_ADDR[1:0] +: 8] == FLAG_VAL));

  a_r7_lane_count: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> ($countones(wr_be) == (32'd1 << wr_size)));

  a_r8_nest_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    nest_err |-> $past(trap_req));

endmodule

bind exc_entry_seq exc_entry_seq_chk #(
  .WORD_W    (WORD_W),
  .PSW_W     (PSW_W),
  .IE_POS    (IE_POS),
  .VECTOR    (VECTOR),
  .FLAG_ADDR (FLAG_ADDR),
  .FLAG_VAL  (FLAG_VAL)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .trap_req   (trap_req),
  .wr_valid   (wr_valid),
  .wr_ready   (wr_ready),
  .wr_addr    (wr_addr),
  .wr_data    (wr_data),
  .wr_be      (wr_be),
  .wr_size    (wr_size),
  .new_pc     (new_pc),
  .new_psw    (new_psw),
  .entry_done (entry_done),
  .entry_busy (entry_busy),
  .nest_err   (nest_err)
);

// File: tb/exc_entry_seq_test.sv
`timescale 1ns/1ps
module exc_entry_seq_test;

  localparam logic [31:0] VEC_PC  = 32'h4000_0008;
  localparam logic [31:0] FLG_A   = 32'h3400_0103;
  localparam logic [15:0] IE_CLR  = 16'hF7FF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trap_req = 1'b0, trap_cause = 1'b0, flag_wr_en = 1'b0, wr_ready = 1'b1;
  logic [31:0] cur_pc = '0, cur_sp = '0;
  logic [15:0] cur_psw = '0;
  logic        wr_valid, entry_cause, entry_done, entry_busy, nest_err;
  logic [31:0] wr_addr, wr_data, new_pc, new_sp;
  logic [3:0]  wr_be;
  logic [1:0]  wr_size;
  logic [15:0] new_psw;

  int checks = 0, fails = 0, cyc = 0;
  bit finished = 0;

  // write log, filled at the falling edge before each completing handshake
  logic [31:0] la [8];
  logic [31:0] ld [8];
  logic [3:0]  lb [8];
  logic [1:0]  ls [8];
  int log_n = 0, nest_cnt = 0;

  always #2.5 clk = ~clk;

  exc_entry_seq uut (
    .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .trap_cause(trap_cause),
    .cur_pc(cur_pc), .cur_psw(cur_psw), .cur_sp(cur_sp), .flag_wr_en(flag_wr_en),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_be(wr_be), .wr_size(wr_size), .new_pc(new_pc), .new_psw(new_psw),
    .new_sp(new_sp), .entry_cause(entry_cause), .entry_done(entry_done),
    .entry_busy(entry_busy), .nest_err(nest_err)
  );

  always @(negedge clk) begin
    if (rst_n && wr_valid && wr_ready && log_n < 8) begin
      la[log_n] = wr_addr; ld[log_n] = wr_data; lb[log_n] = wr_be; ls[log_n] = wr_size;
      log_n = log_n + 1;
    end
    if (rst_n && nest_err) nest_cnt = nest_cnt + 1;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 20000);
      summary();
    end
  end

  task automatic wait_done(output bit seen);
    seen = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (entry_done) begin seen = 1; break; end
    end
  endtask

  // pc, psw, sp, flag option, cause
  localparam logic [81:0] VECS [4] = '{
    {32'h0000_1234, 16'h0800, 32'h0000_8000, 1'b0, 1'b0},
    {32'hDEAD_BEEC, 16'hFFFF, 32'h4000_1000, 1'b1, 1'b1},
    {32'h4000_0100, 16'h0000, 32'h0000_0000, 1'b0, 1'b1},
    {32'h1234_5678, 16'h0A5A, 32'h0010_0010, 1'b1, 1'b0}
  };

  initial begin
    bit seen;
    // R1: reset state
    repeat (3) @(negedge clk);
    check(!wr_valid && !entry_done && !entry_busy && !nest_err, "R1", "strobes in reset",
          {28'h0, wr_valid, entry_done, entry_busy, nest_err}, 32'h0);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    check(new_pc == 0 && new_sp == 0 && new_psw == 0 && !wr_valid, "R1", "state after release",
          new_pc | new_sp | {16'h0, new_psw}, 32'h0);

    // table walk with an always-ready memory
    for (int v = 0; v < 4; v++) begin
      logic [31:0] pc, sp; logic [15:0] psw; logic brd, cs;
      {pc, psw, sp, brd, cs} = VECS[v];
      log_n = 0;
      @(posedge clk); #1;
      cur_pc = pc; cur_psw = psw; cur_sp = sp; flag_wr_en = brd; trap_cause = cs; trap_req = 1;
      @(posedge clk); #1 trap_req = 0; cur_pc = '1; cur_sp = '1; cur_psw = '1;
      @(negedge clk);
      check(entry_busy, "R9", "busy after accept", {31'h0, entry_busy}, 32'h1);
      wait_done(seen);
      check(seen, "R6", "done seen", {31'h0, seen}, 32'h1);
      check(log_n == (brd ? 3 : 2), "R4", "write count", log_n, brd ? 3 : 2);
      check(la[0] == sp - 32'd4 && ld[0] == pc && lb[0] == 4'hF && ls[0] == 2'd2,
            "R2", "PC word write", la[0] ^ ld[0], (sp - 32'd4) ^ pc);
      check(la[1] == sp - 32'd8 && ld[1] == {16'h0, psw} && lb[1] == 4'b0011 && ls[1] == 2'd1,
            "R3", "PSW half write (R7 lanes)", ld[1], {16'h0, psw});
      if (brd)
        check(la[2] == FLG_A && ld[2] == 32'h0400_0000 && lb[2] == 4'b1000 && ls[2] == 2'd0,
              "R4", "flag byte write", ld[2], 32'h0400_0000);
      check(new_pc == VEC_PC, "R6", "vector", new_pc, VEC_PC);
      check(new_psw == (psw & IE_CLR), "R6", "psw IE cleared", {16'h0, new_psw}, {16'h0, psw & IE_CLR});
      check(new_sp == sp - 32'd8, "R6", "sp minus 8", new_sp, sp - 32'd8);
      check(!entry_busy, "R9", "not busy at done", {31'h0, entry_busy}, 32'h0);
      check(entry_cause == cs, "R10", "cause reported", {31'h0, entry_cause}, {31'h0, cs});
      @(negedge clk);
      check(!entry_done && new_sp == sp - 32'd8, "R6", "single done, state held",
            new_sp, sp - 32'd8);
    end

    // R5: backpressure on the first write
    log_n = 0; wr_ready = 0;
    @(posedge clk); #1;
    cur_pc = 32'hCAFE_0000; cur_psw = 16'h0801; cur_sp = 32'h0000_3000; flag_wr_en = 0; trap_req = 1;
    @(posedge clk); #1 trap_req = 0;
    begin
      bit steady = 1;
      for (int i = 0; i < 4; i++) begin
        @(negedge clk);
        if (!(wr_valid && wr_addr == 32'h2FFC && wr_data == 32'hCAFE_0000 && !entry_done))
          steady = 0;
      end
      check(steady && log_n == 0, "R5", "write held while stalled", wr_addr, 32'h2FFC);
    end
    @(posedge clk); #1 wr_ready = 1;
    wait_done(seen);
    check(seen && log_n == 2 && la[0] == 32'h2FFC && la[1] == 32'h2FF8, "R5", "order after stall",
          la[1], 32'h2FF8);

    // R8: nested request while busy
    log_n = 0; nest_cnt = 0;
    @(posedge clk); #1;
    cur_pc = 32'h0000_0400; cur_psw = 16'h0800; cur_sp = 32'h0000_2000; flag_wr_en = 0; trap_req = 1;
    @(posedge clk); #1;   // accepted; hold request one more cycle while busy
    @(posedge clk); #1 trap_req = 0;
    wait_done(seen);
    check(seen && new_sp == 32'h1FF8, "R8", "first commit", new_sp, 32'h1FF8);
    @(negedge clk);
    check(entry_done && new_sp == 32'h1FF0 && new_pc == VEC_PC && !new_psw[11], "R8",
          "chained commit", new_sp, 32'h1FF0);
    @(negedge clk);
    check(!entry_done && !entry_busy, "R8", "chain ends", {31'h0, entry_done}, 32'h0);
    check(nest_cnt == 1, "R8", "nest error count", nest_cnt, 1);
    check(log_n == 2, "R8", "no extra writes", log_n, 2);

    repeat (3) @(negedge clk);
    check(new_sp == 32'h1FF0 && !wr_valid, "R6", "idle hold", new_sp, 32'h1FF0);
    summary();
  end

endmodule